// File: doc/BRIEF.md
# Byte-Wide Bus Partition Decoder

This block sits between an 8051-style processor core and a single onboard nonvolatile SRAM that holds both code and data. For every program fetch or data access it decides, one clock after the request, where the access goes. The choices are the onboard RAM over a non-multiplexed byte-wide bus, one of two peripheral windows, or the multiplexed expanded bus. It drives the RAM chip enable, the two peripheral enables, an expanded-bus select and the shared write strobe.

Software programs four small registers through a write port in the style of a special-function register. A program limit and a data limit set how much of each 64 KB space is mapped onto the RAM. A partition point marks the part of the RAM that holds code. A mode bit hands the upper half of data space to the peripheral enables. A data write that lands in the code part of the RAM never produces a write strobe. Instead it raises a one-cycle violation flag. Any register can be rewritten while accesses are running, and the very next access uses the new value.

Top module: `bwbus_decoder`

## Requirements
- R1: After reset, all enables are inactive, `ext_en` and `prot_flag` are 0, and the registers hold their defaults. Both limits and the partition point cover the whole 64 KB, and the mode bit is 0. A fetch at F000h therefore reaches the RAM, and every data write to the RAM is blocked.
- R2: A program fetch whose address, divided into 4 KB units, is below the program limit asserts `ram_ce_n` one cycle later. Any other fetch sets `ext_en`.
- R3: With the mode bit at 0, or for a data address below 8000h, a data access whose 4 KB unit is below the data limit asserts `ram_ce_n`. Any other such access sets `ext_en`. This includes the upper two 16 KB windows.
- R4: A data write to the RAM whose 4 KB unit is below the partition point keeps `bw_we_n` high and pulses `prot_flag` for that cycle, with `ram_ce_n` still asserted. Data reads there are not flagged.
- R5: A data write to the RAM at or above the partition point, or to a peripheral window, drives `bw_we_n` low. The strobe is never low while `ext_en` is 1.
- R6: With the mode bit at 1, data accesses from 8000h to BFFFh assert `plo_ce_n` and never `ram_ce_n`.
- R7: With the mode bit at 1, data accesses from C000h to FFFFh assert `phi_ce_n`.
- R8: During a peripheral access, `bw_addr[15:14]` is 0 and `bw_addr[13:0]` carries the low 14 bits of the request. For RAM and expanded accesses, `bw_addr` carries the full address.
- R9: At most one of `ram_ce_n` (low), `plo_ce_n` (low), `phi_ce_n` (low) and `ext_en` (high) is active in any cycle.
- R10: The registers are selected by `cfg_sel`: 0 is the program limit, 1 the data limit, 2 the partition point, and 3 the mode bit (`cfg_wdata[0]`). Limit and partition values are in 4 KB units and are clamped to 16. A write takes effect for the access requested in the next cycle.
- R11: A program fetch never drives `bw_we_n` low and never raises `prot_flag`, even with `acc_write` at 1. It is not affected by the mode bit.
- R12: A cycle with `acc_valid` at 0 produces an idle bus one cycle later. All enables are inactive, `ext_en` and `prot_flag` are 0, and `bw_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 8 | Register write data |
| acc_valid | input | 1 | Access request this cycle |
| acc_prog | input | 1 | 1 for a program fetch, 0 for a data access |
| acc_write | input | 1 | 1 for a data write |
| acc_addr | input | 16 | Access address |
| bw_addr | output | 16 | Byte-wide bus address |
| ram_ce_n | output | 1 | Onboard RAM enable, active low |
| plo_ce_n | output | 1 | Peripheral window 8000h-BFFFh enable, active low |
| phi_ce_n | output | 1 | Peripheral window C000h-FFFFh enable, active low |
| ext_en | output | 1 | Access routed to the expanded bus |
| bw_we_n | output | 1 | Byte-wide write strobe, active low |
| prot_flag | output | 1 | One-cycle blocked-write flag |

## Verification
On every cycle, the assertions check the rules that need only the ports. These are the exclusivity of the enables and the fact that a flagged write carries no strobe. They also check the zeroed upper address bits during peripheral access, that fetches never write, and the idle bus after an empty cycle. Whether each address lands in the right target depends on register contents the checker does not see. The limits, the partition point, clamping, the mode bit and the timing of register updates are therefore shown only by the bench's scenarios. The bench compares every output field against an independent model of the register state.

// File: rtl/bwd_pkg.sv
// Shared types for the byte-wide bus partition decoder.
// Assumes a 16-bit address space for both program and data.
package bwd_pkg;
    localparam int ADDR_W = 16;
    localparam int PER_W  = 14;   // peripheral windows are 16 KB

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_RAM  = 3'd1,
        TGT_PLO  = 3'd2,
        TGT_PHI  = 3'd3,
        TGT_EXT  = 3'd4
    } target_e;

    typedef struct packed {
        target_e             tgt;
        logic                wr;     // write strobe wanted
        logic                viol;   // blocked write
        logic [ADDR_W-1:0]   addr;
    } route_t;
endpackage

// File: rtl/bwd_cfg_regs.sv
// Configuration registers: program limit, data limit, partition point
// and peripheral mode bit. Limits are counted in granules of 2**GRAN_W
// bytes and clamped to the number of granules in the space.
// Assumes the granule count fits in the 8-bit write data.
module bwd_cfg_regs #(
    parameter int ADDR_W = 16,
    parameter int GRAN_W = 12,
    localparam int UW    = ADDR_W - GRAN_W,
    localparam int LIM_W = UW + 1,
    localparam int NUNIT = 2 ** UW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [7:0]       cfg_wdata,
    output logic [LIM_W-1:0] prog_lim,
    output logic [LIM_W-1:0] data_lim,
    output logic [LIM_W-1:0] part_pt,
    output logic             per_mode
);
    logic [LIM_W-1:0] clamped;
    logic [LIM_W-1:0] lim_q [3];

    // Saturate an incoming limit value to the full space.
    always_comb begin
        if (cfg_wdata > 8'(NUNIT))
            clamped = LIM_W'(NUNIT);
        else
            clamped = cfg_wdata[LIM_W-1:0];
    end

    // One register per limit-style field, selected by index.
    for (genvar gi = 0; gi < 3; gi++) begin : g_lim
        always_ff @(posedge clk) begin
            if (!rst_n)
                lim_q[gi] <= LIM_W'(NUNIT);
            else if (cfg_we && cfg_sel == 2'(gi))
                lim_q[gi] <= clamped;
        end
    end

    // Peripheral mode bit lives at select 3.
    always_ff @(posedge clk) begin
        if (!rst_n)
            per_mode <= 1'b0;
        else if (cfg_we && cfg_sel == 2'd3)
            per_mode <= cfg_wdata[0];
    end

    assign prog_lim = lim_q[0];
    assign data_lim = lim_q[1];
    assign part_pt  = lim_q[2];
endmodule

// File: rtl/bwd_addr_decode.sv
// Combinational route decision for one access. Program fetches compare
// against the program limit; data accesses go to the peripheral windows
// when the mode bit is set and the top address bit is 1, otherwise
// against the data limit. RAM data writes below the partition point
// are turned into violations with no write strobe.
module bwd_addr_decode
    import bwd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int GRAN_W = 12,
    localparam int UW    = ADDR_W - GRAN_W,
    localparam int LIM_W = UW + 1
) (
    input  logic              valid,
    input  logic              prog,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LIM_W-1:0]  prog_lim,
    input  logic [LIM_W-1:0]  data_lim,
    input  logic [LIM_W-1:0]  part_pt,
    input  logic              per_mode,
    output route_t            route
);
    logic [LIM_W-1:0] unit;
    logic             in_prog, in_data, in_code, per_hit;

    // Granule index and range comparisons.
    always_comb begin
        unit    = {1'b0, addr[ADDR_W-1:GRAN_W]};
        in_prog = unit < prog_lim;
        in_data = unit < data_lim;
        in_code = unit < part_pt;
        per_hit = per_mode && addr[ADDR_W-1];
    end

    // Pick the target, strobe and violation for this access.
    always_comb begin
        route      = '0;
        route.tgt  = TGT_NONE;
        if (valid) begin
            route.addr = addr;
            if (prog) begin
                route.tgt = in_prog ? TGT_RAM : TGT_EXT;
            end else if (per_hit) begin
                route.tgt  = addr[ADDR_W-2] ? TGT_PHI : TGT_PLO;
                route.addr = {{(ADDR_W-PER_W){1'b0}}, addr[PER_W-1:0]};
                route.wr   = write;
            end else if (in_data) begin
                route.tgt  = TGT_RAM;
                route.wr   = write && !in_code;
                route.viol = write && in_code;
            end else begin
                route.tgt = TGT_EXT;
            end
        end
    end
endmodule

// File: rtl/bwd_bus_drive.sv
// Output register stage: turns a route decision into the registered
// active-low enables, expanded-bus select, strobe, address and flag.
module bwd_bus_drive
    import bwd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  route_t            route,
    output logic [ADDR_W-1:0] bw_addr,
    output logic              ram_ce_n,
    output logic              plo_ce_n,
    output logic              phi_ce_n,
    output logic              ext_en,
    output logic              bw_we_n,
    output logic              prot_flag
);
    // Register every bus output from the decoded route.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bw_addr   <= '0;
            ram_ce_n  <= 1'b1;
            plo_ce_n  <= 1'b1;
            phi_ce_n  <= 1'b1;
            ext_en    <= 1'b0;
            bw_we_n   <= 1'b1;
            prot_flag <= 1'b0;
        end else begin
            bw_addr   <= route.addr;
            ram_ce_n  <= route.tgt != TGT_RAM;
            plo_ce_n  <= route.tgt != TGT_PLO;
            phi_ce_n  <= route.tgt != TGT_PHI;
            ext_en    <= route.tgt == TGT_EXT;
            bw_we_n   <= !route.wr;
            prot_flag <= route.viol;
        end
    end
endmodule

// File: rtl/bwbus_decoder.sv
// Top of the byte-wide bus partition decoder: configuration registers,
// access decode and registered bus outputs. Outputs follow the request
// by one clock; register writes affect the next cycle's request.
module bwbus_decoder
    import bwd_pkg::*;
#(
    parameter int GRAN_W = 12,
    localparam int UW    = ADDR_W - GRAN_W,
    localparam int LIM_W = UW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_prog,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] bw_addr,
    output logic              ram_ce_n,
    output logic              plo_ce_n,
    output logic              phi_ce_n,
    output logic              ext_en,
    output logic              bw_we_n,
    output logic              prot_flag
);
    logic [LIM_W-1:0] prog_lim, data_lim, part_pt;
    logic             per_mode;
    route_t           route;

    bwd_cfg_regs #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .prog_lim(prog_lim), .data_lim(data_lim),
        .part_pt(part_pt), .per_mode(per_mode)
    );

    bwd_addr_decode #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_dec (
        .valid(acc_valid), .prog(acc_prog), .write(acc_write),
        .addr(acc_addr),
        .prog_lim(prog_lim), .data_lim(data_lim),
        .part_pt(part_pt), .per_mode(per_mode),
        .route(route)
    );

    bwd_bus_drive #(.ADDR_W(ADDR_W)) u_drv (
        .clk(clk), .rst_n(rst_n), .route(route),
        .bw_addr(bw_addr), .ram_ce_n(ram_ce_n),
        .plo_ce_n(plo_ce_n), .phi_ce_n(phi_ce_n),
        .ext_en(ext_en), .bw_we_n(bw_we_n), .prot_flag(prot_flag)
    );
endmodule

// File: rtl/bwbus_decoder_chk.sv
// Port-level checker for the byte-wide bus partition decoder.
module bwbus_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_prog,
    input logic [15:0] bw_addr,
    input logic        ram_ce_n,
    input logic        plo_ce_n,
    input logic        phi_ce_n,
    input logic        ext_en,
    input logic        bw_we_n,
    input logic        prot_flag
);
    // R9
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~ram_ce_n, ~plo_ce_n, ~phi_ce_n, ext_en}));

    // R4
    blocked_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_flag |-> (bw_we_n && !ram_ce_n));

    // R5
    no_ext_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bw_we_n |-> !ext_en);

    // R8
    per_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!plo_ce_n || !phi_ce_n) |-> (bw_addr[15:14] == 2'b00));

    // R11
    fetch_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_prog) |=> (bw_we_n && !prot_flag));

    // R12
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (ram_ce_n && plo_ce_n && phi_ce_n && !ext_en
                        && bw_we_n && !prot_flag && bw_addr == 16'h0));
endmodule

bind bwbus_decoder bwbus_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_prog(acc_prog),
    .bw_addr(bw_addr), .ram_ce_n(ram_ce_n), .plo_ce_n(plo_ce_n),
    .phi_ce_n(phi_ce_n), .ext_en(ext_en), .bw_we_n(bw_we_n),
    .prot_flag(prot_flag)
);

// File: tb/bwbus_decoder_test.sv
// Scoreboard bench: the driver pushes expected bus states, the monitor
// compares them one clock later, 2 ns after the rising edge.
module bwbus_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        acc_valid = 1'b0, acc_prog = 1'b0, acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [15:0] bw_addr;
    logic        ram_ce_n, plo_ce_n, phi_ce_n, ext_en, bw_we_n, prot_flag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [21:0] exp_q[$];
    string       tag_q[$];

    // Shadow of the register state, from the requirement text.
    int m_plim = 16, m_dlim = 16, m_part = 16;
    bit m_mode = 1'b0;

    always #5 clk = ~clk;

    bwbus_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_prog(acc_prog),
        .acc_write(acc_write), .acc_addr(acc_addr), .bw_addr(bw_addr),
        .ram_ce_n(ram_ce_n), .plo_ce_n(plo_ce_n), .phi_ce_n(phi_ce_n),
        .ext_en(ext_en), .bw_we_n(bw_we_n), .prot_flag(prot_flag)
    );

    // Packed expectation: {ram_ce_n, plo_ce_n, phi_ce_n, ext_en, we_n, flag, addr}
    function automatic logic [21:0] expect_of(bit v, bit p, bit w, logic [15:0] a);
        int u = int'(a[15:12]);
        if (!v) return {6'b111010, 16'h0};
        if (p) return (u < m_plim) ? {6'b011010, a} : {6'b111110, a};
        if (m_mode && a[15])
            return a[14] ? {4'b1100, !w, 1'b0, 2'b00, a[13:0]}
                         : {4'b1010, !w, 1'b0, 2'b00, a[13:0]};
        if (u < m_dlim)
            return {4'b0110, !(w && u >= m_part), (w && u < m_part), a};
        return {6'b111110, a};
    endfunction

    task automatic step(bit v, bit p, bit w, logic [15:0] a, string tag);
        @(negedge clk);
        cfg_we = 1'b0;
        acc_valid = v; acc_prog = p; acc_write = w; acc_addr = a;
        exp_q.push_back(expect_of(v, p, w, a));
        tag_q.push_back(tag);
    endtask

    task automatic cfg(logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b0; acc_prog = 1'b0; acc_write = 1'b0; acc_addr = '0;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        exp_q.push_back(expect_of(1'b0, 1'b0, 1'b0, 16'h0));
        tag_q.push_back("R10");
        case (sel)
            2'd0: m_plim = (d > 16) ? 16 : int'(d);
            2'd1: m_dlim = (d > 16) ? 16 : int'(d);
            2'd2: m_part = (d > 16) ? 16 : int'(d);
            default: m_mode = d[0];
        endcase
    endtask

    // Monitor: compare one expectation per cycle.
    always begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            logic [21:0] e;
            logic [21:0] got;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            got = {ram_ce_n, plo_ce_n, phi_ce_n, ext_en, bw_we_n, prot_flag, bw_addr};
            total++;
            if (got !== e) begin
                bad++;
                $display("FAIL %s: got %h expected %h", t, got, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        total++;
        // R1: reset state at the ports
        if ({ram_ce_n, plo_ce_n, phi_ce_n, ext_en, bw_we_n, prot_flag} !== 6'b111010) begin
            bad++;
            $display("FAIL R1: got %b expected 111010",
                     {ram_ce_n, plo_ce_n, phi_ce_n, ext_en, bw_we_n, prot_flag});
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: defaults map everything as program RAM
        step(1, 1, 0, 16'hF000, "R1");
        step(1, 0, 1, 16'h1234, "R1");
        step(1, 0, 1, 16'hE000, "R4");
        // R4 / R5 around a 16 KB partition
        cfg(2'd2, 8'd4);
        step(1, 0, 1, 16'h4000, "R5");
        step(1, 0, 1, 16'h3FFF, "R4");
        step(1, 0, 0, 16'h3FFF, "R4");
        step(0, 0, 0, 16'h0000, "R12");
        // R2 program limit at 32 KB
        cfg(2'd0, 8'd8);
        step(1, 1, 0, 16'h7FFF, "R2");
        step(1, 1, 0, 16'h8000, "R2");
        // R3 data limit at 40 KB, mode 0, upper windows go by range
        cfg(2'd1, 8'd10);
        step(1, 0, 0, 16'h9FFF, "R3");
        step(1, 0, 0, 16'hA000, "R3");
        step(1, 0, 1, 16'hC000, "R3");
        step(1, 0, 0, 16'hFFFF, "R3");
        // R6 / R7 / R8 peripheral windows
        cfg(2'd3, 8'h01);
        step(1, 0, 1, 16'h8000, "R6");
        step(1, 0, 0, 16'hBFFF, "R6");
        step(1, 0, 0, 16'hC000, "R7");
        step(1, 0, 1, 16'hFFFF, "R8");
        step(1, 0, 1, 16'h7FFF, "R3");
        // R11 fetches ignore write and the mode bit
        step(1, 1, 1, 16'h9000, "R11");
        cfg(2'd0, 8'd16);
        step(1, 1, 1, 16'hC000, "R11");
        step(1, 1, 1, 16'h2000, "R11");
        // R10 immediate effect and clamping
        cfg(2'd2, 8'd2);
        step(1, 0, 1, 16'h2000, "R10");
        step(1, 0, 1, 16'h1FFF, "R10");
        cfg(2'd3, 8'hFE);
        cfg(2'd1, 8'd31);
        step(1, 0, 0, 16'hFFFF, "R10");
        step(1, 0, 1, 16'hC123, "R9");
        step(0, 1, 1, 16'hFFFF, "R12");
        step(0, 0, 0, 16'h0000, "R12");
        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule